// File: doc/BRIEF.md
# Banked Vector Memory Access Unit

This block carries out vector loads and stores against a word-interleaved memory of sixteen banks held inside the block. A command gives a base byte address, an addressing mode, an element width, a vector length and, for stride mode, a byte stride. The unit then walks the elements in ascending index order, forms each element's address and sends it to its bank. For gather and scatter it reads a per-element byte offset from an index vector port.

Every bank needs a recovery interval after each access. Issue stalls in place while the bank of the next element is still recovering. Requests are never dropped and never reordered. Stores take their element data from a register read port in the cycle the element issues. Loads return data through a register write port a fixed number of cycles after issue, and the data arrives in ascending element index. A single-cycle completion pulse closes each command.

Top module: `vec_bank_lsu`

## Requirements
- R1: In unit-stride mode (mode code 0, and the unused code 3), element i sits at byte address base + i × (element bytes), modulo 2^ADDR_W.
- R2: In constant-stride mode (mode code 1), element i sits at byte address base + i × stride, modulo 2^ADDR_W.
- R3: In indexed mode (mode code 2), element i sits at base + idx[i], where idx[i] is read on the index port at address i. A scatter that names the same location twice leaves the value of the higher element index.
- R4: Width code 0/1/2/3 selects 8/16/32/64-bit elements. A store keeps only the low bits of the element in its bank entry and zero-fills the rest. A load returns the entry's low bits, zero-extended.
- R5: The element address is the byte address shifted right by the width code. The bank is bits [3:0] of the element address and the row is the next bits, modulo the bank depth.
- R6: After an access, a bank accepts no other access for 4 cycles. The next element waits in order until its bank is free, so a stream that hits one bank issues every 4 cycles.
- R7: Load data for an element leaves on the write port 12 cycles after that element issues. On a conflict-free load that starts in cycle s, element i is written in cycle s+13+i.
- R8: A load writes each element index from 0 to length−1 exactly once, in ascending order. A store writes nothing on the write port.
- R9: A vector length of 0 makes no memory access and writes nothing. Done still pulses, two cycles after start.
- R10: Done is a one-cycle pulse. For a load it comes in the cycle after the last element write. For a store it comes in the cycle after the last element issues. Done and the write enable are low after reset.
- R11: A start while a command is in progress is ignored and does not alter the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a command when idle |
| store_i | input | 1 | 1 = store, 0 = load |
| mode_i | input | 2 | Addressing mode code |
| wsz_i | input | 2 | Element width code |
| base_i | input | ADDR_W | Base byte address |
| stride_i | input | ADDR_W | Byte stride for stride mode |
| vlen_i | input | VL_W | Element count, 0 to MAX_VL |
| idx_raddr_o | output | IDX_W | Element index for the index vector read |
| idx_rdata_i | input | ADDR_W | Byte offset of that element |
| st_raddr_o | output | IDX_W | Element index for the store data read |
| st_rdata_i | input | 64 | Store data of that element |
| wr_en_o | output | 1 | Load element write strobe |
| wr_idx_o | output | IDX_W | Destination element index |
| wr_data_o | output | 64 | Load element data, zero-extended |
| done_o | output | 1 | Command complete pulse |

## Verification
Bank recovery and element issue meet in one cycle whenever the next element maps to a bank that is still busy. The bench provokes this with a zero stride, with strides that land on the same bank at one width but not at another, and with random gathers. It judges the result from the exact cycles of the load writes and checks the data and order against its own memory model. The write port's last write and done also fall together at the end of a load; the bench checks that done follows the final write by one cycle and that nothing is written afterwards.

// File: rtl/vlsu_pkg.sv
package vlsu_pkg;

  localparam int unsigned ELEM_W = 64;

  typedef logic [ELEM_W-1:0] elem_t;

  typedef enum logic [1:0] {
    AM_UNIT   = 2'd0,
    AM_STRIDE = 2'd1,
    AM_INDEX  = 2'd2,
    AM_RSVD   = 2'd3
  } amode_e;

  // keep the low 8/16/32/64 bits of an element, zero the rest
  function automatic elem_t fit_elem(input elem_t d, input logic [1:0] w);
    elem_t r;
    unique case (w)
      2'd0:    r = {56'd0, d[7:0]};
      2'd1:    r = {48'd0, d[15:0]};
      2'd2:    r = {32'd0, d[31:0]};
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/vlsu_agen.sv
module vlsu_agen
  import vlsu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int VL_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  amode_e            mode_i,
  input  logic [1:0]        wsz_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] idx_off_i,
  output logic [ADDR_W-1:0] ea_o,
  output logic [VL_W-1:0]   cnt_o,
  output logic [1:0]        wsz_o
);

  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] step_q, step_d;
  logic [ADDR_W-1:0] run_q, run_d;
  amode_e            mode_q, mode_d;
  logic [1:0]        wsz_q, wsz_d;
  logic [VL_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0] byte_addr;

  always_comb begin
    base_d = base_q;
    step_d = step_q;
    run_d  = run_q;
    mode_d = mode_q;
    wsz_d  = wsz_q;
    cnt_d  = cnt_q;
    if (ld_i) begin
      base_d = base_i;
      step_d = (mode_i == AM_STRIDE) ? stride_i : (ADDR_W'(1) << wsz_i);
      run_d  = base_i;
      mode_d = mode_i;
      wsz_d  = wsz_i;
      cnt_d  = '0;
    end else if (adv_i) begin
      run_d = run_q + step_q;
      cnt_d = cnt_q + VL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      step_q <= '0;
      run_q  <= '0;
      mode_q <= AM_UNIT;
      wsz_q  <= '0;
      cnt_q  <= '0;
    end else begin
      base_q <= base_d;
      step_q <= step_d;
      run_q  <= run_d;
      mode_q <= mode_d;
      wsz_q  <= wsz_d;
      cnt_q  <= cnt_d;
    end
  end

  assign byte_addr = (mode_q == AM_INDEX) ? (base_q + idx_off_i) : run_q;
  assign ea_o      = byte_addr >> wsz_q;
  assign cnt_o     = cnt_q;
  assign wsz_o     = wsz_q;

endmodule

// File: rtl/vlsu_bank_busy.sv
module vlsu_bank_busy #(
  parameter int NB     = 16,
  parameter int BUSY   = 4,
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit_i,
  input  logic [BANK_W-1:0] hit_bank_i,
  output logic [NB-1:0]     free_o
);

  localparam int CW = $clog2(BUSY + 1);
  localparam logic [CW-1:0] RELOAD = CW'(BUSY - 1);
  localparam logic [CW-1:0] GAP_MAX = CW'(BUSY);

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic          sel;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW-1:0] gap_q;

    assign sel = hit_i && (hit_bank_i == BANK_W'(b));

    always_comb begin
      cnt_d = cnt_q;
      if (sel)                cnt_d = RELOAD;
      else if (cnt_q != '0)   cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_d;
    end

    assign free_o[b] = (cnt_q == '0);

    // independent cycles-since-access counter for the gap check
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                gap_q <= GAP_MAX;
      else if (sel)              gap_q <= CW'(1);
      else if (gap_q != GAP_MAX) gap_q <= gap_q + CW'(1);
    end

    a_r6_bank_gap: assert property (@(posedge clk) disable iff (!rst_n)
      sel |-> (gap_q >= GAP_MAX));
  end

endmodule

// File: rtl/vlsu_bank.sv
module vlsu_bank
  import vlsu_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [ROW_W-1:0] row_i,
  input  elem_t            wdata_i,
  output elem_t            rdata_o
);

  elem_t mem_q [DEPTH];
  elem_t rd_q;

  always_ff @(posedge clk) begin
    if (we_i) mem_q[row_i] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (re_i) rd_q <= mem_q[row_i];
  end

  assign rdata_o = rd_q;

endmodule

// File: rtl/vlsu_ret_pipe.sv
module vlsu_ret_pipe
  import vlsu_pkg::*;
#(
  parameter int NB     = 16,
  parameter int BANK_W = 4,
  parameter int IDX_W  = 4,
  parameter int LAT    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v_i,
  input  logic [IDX_W-1:0]  in_idx_i,
  input  logic [BANK_W-1:0] in_bank_i,
  input  logic [1:0]        in_wsz_i,
  input  elem_t             bank_rd_i [NB],
  output logic              out_v_o,
  output logic [IDX_W-1:0]  out_idx_o,
  output elem_t             out_data_o
);

  // stage 0: tag travelling alongside the bank's registered read
  logic              t_v_q;
  logic [IDX_W-1:0]  t_idx_q;
  logic [BANK_W-1:0] t_bank_q;
  logic [1:0]        t_wsz_q;
  elem_t             pick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) t_v_q <= 1'b0;
    else        t_v_q <= in_v_i;
  end

  always_ff @(posedge clk) begin
    if (in_v_i) begin
      t_idx_q  <= in_idx_i;
      t_bank_q <= in_bank_i;
      t_wsz_q  <= in_wsz_i;
    end
  end

  assign pick = fit_elem(bank_rd_i[t_bank_q], t_wsz_q);

  logic [LAT-1:1]   sv_q;
  logic [IDX_W-1:0] sidx_q [1:LAT-1];
  elem_t            sdat_q [1:LAT-1];

  for (genvar k = 1; k < LAT; k++) begin : g_stage
    if (k == 1) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sv_q[k] <= 1'b0;
        else        sv_q[k] <= t_v_q;
      end
      always_ff @(posedge clk) begin
        if (t_v_q) begin
          sidx_q[k] <= t_idx_q;
          sdat_q[k] <= pick;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sv_q[k] <= 1'b0;
        else        sv_q[k] <= sv_q[k-1];
      end
      always_ff @(posedge clk) begin
        if (sv_q[k-1]) begin
          sidx_q[k] <= sidx_q[k-1];
          sdat_q[k] <= sdat_q[k-1];
        end
      end
    end
  end

  assign out_v_o    = sv_q[LAT-1];
  assign out_idx_o  = sidx_q[LAT-1];
  assign out_data_o = sdat_q[LAT-1];

  // order tracking for the ascending-index check
  logic [IDX_W-1:0] last_q;
  logic             seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= '0;
      seen_q <= 1'b0;
    end else if (out_v_o) begin
      last_q <= out_idx_o;
      seen_q <= 1'b1;
    end
  end

  a_r8_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v_o && seen_q && out_idx_o != '0) |-> (out_idx_o == last_q + IDX_W'(1)));

endmodule

// File: rtl/vec_bank_lsu.sv
module vec_bank_lsu
  import vlsu_pkg::*;
#(
  parameter int NBANKS     = 16,
  parameter int BANK_DEPTH = 16,
  parameter int BUSY_CYC   = 4,
  parameter int RET_LAT    = 12,
  parameter int MAX_VL     = 16,
  parameter int ADDR_W     = 16,
  localparam int VL_W      = $clog2(MAX_VL + 1),
  localparam int IDX_W     = $clog2(MAX_VL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              store_i,
  input  logic [1:0]        mode_i,
  input  logic [1:0]        wsz_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] stride_i,
  input  logic [VL_W-1:0]   vlen_i,
  output logic [IDX_W-1:0]  idx_raddr_o,
  input  logic [ADDR_W-1:0] idx_rdata_i,
  output logic [IDX_W-1:0]  st_raddr_o,
  input  logic [63:0]       st_rdata_i,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [63:0]       wr_data_o,
  output logic              done_o
);

  localparam int BANK_W = $clog2(NBANKS);
  localparam int ROW_W  = $clog2(BANK_DEPTH);

  logic              active_q, active_d;
  logic              store_q, store_d;
  logic [VL_W-1:0]   vlen_q, vlen_d;
  logic              done_q, done_d;

  logic              accept;
  logic              pending;
  logic              issue;
  logic              finishing;
  logic [ADDR_W-1:0] ea;
  logic [VL_W-1:0]   cnt;
  logic [1:0]        wsz;
  logic [BANK_W-1:0] bank_id;
  logic [ROW_W-1:0]  row_id;
  logic [NBANKS-1:0] bank_free;
  elem_t             st_word;
  elem_t             bank_rd [NBANKS];

  assign accept = start_i && !active_q;

  vlsu_agen #(
    .ADDR_W (ADDR_W),
    .VL_W   (VL_W)
  ) i_agen (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_i      (accept),
    .base_i    (base_i),
    .stride_i  (stride_i),
    .mode_i    (amode_e'(mode_i)),
    .wsz_i     (wsz_i),
    .adv_i     (issue),
    .idx_off_i (idx_rdata_i),
    .ea_o      (ea),
    .cnt_o     (cnt),
    .wsz_o     (wsz)
  );

  assign bank_id     = BANK_W'(ea);
  assign row_id      = ROW_W'(ea >> BANK_W);
  assign idx_raddr_o = IDX_W'(cnt);
  assign st_raddr_o  = IDX_W'(cnt);
  assign st_word     = fit_elem(st_rdata_i, wsz);

  assign pending = active_q && (cnt < vlen_q);
  assign issue   = pending && bank_free[bank_id];

  vlsu_bank_busy #(
    .NB     (NBANKS),
    .BUSY   (BUSY_CYC),
    .BANK_W (BANK_W)
  ) i_busy (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (issue),
    .hit_bank_i (bank_id),
    .free_o     (bank_free)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_mem
    logic hit;
    assign hit = issue && (bank_id == BANK_W'(b));

    vlsu_bank #(
      .DEPTH (BANK_DEPTH),
      .ROW_W (ROW_W)
    ) i_bank (
      .clk     (clk),
      .we_i    (hit && store_q),
      .re_i    (hit && !store_q),
      .row_i   (row_id),
      .wdata_i (st_word),
      .rdata_o (bank_rd[b])
    );
  end

  vlsu_ret_pipe #(
    .NB     (NBANKS),
    .BANK_W (BANK_W),
    .IDX_W  (IDX_W),
    .LAT    (RET_LAT)
  ) i_ret (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_v_i     (issue && !store_q),
    .in_idx_i   (IDX_W'(cnt)),
    .in_bank_i  (bank_id),
    .in_wsz_i   (wsz),
    .bank_rd_i  (bank_rd),
    .out_v_o    (wr_en_o),
    .out_idx_o  (wr_idx_o),
    .out_data_o (wr_data_o)
  );

  always_comb begin
    finishing = 1'b0;
    if (active_q) begin
      if (vlen_q == '0)
        finishing = 1'b1;
      else if (store_q)
        finishing = issue && (cnt == vlen_q - VL_W'(1));
      else
        finishing = wr_en_o && (VL_W'(wr_idx_o) == vlen_q - VL_W'(1));
    end
  end

  always_comb begin
    active_d = active_q;
    store_d  = store_q;
    vlen_d   = vlen_q;
    done_d   = finishing;
    if (accept) begin
      active_d = 1'b1;
      store_d  = store_i;
      vlen_d   = vlen_i;
    end else if (finishing) begin
      active_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      store_q  <= 1'b0;
      vlen_q   <= '0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      store_q  <= store_d;
      vlen_q   <= vlen_d;
      done_q   <= done_d;
    end
  end

  assign done_o = done_q;

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r9_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && vlen_q == '0) |-> !wr_en_o);

  a_r8_write_in_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> (active_q && !store_q));

  a_r11_hold_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && start_i) |=> ($stable(vlen_q) && $stable(store_q)));

endmodule

// File: tb/test_vec_bank_lsu.sv
module test_vec_bank_lsu;

  localparam int AW  = 16;
  localparam int MVL = 16;
  localparam int VLW = 5;
  localparam int IW  = 4;

  logic          clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic          start, store;
  logic [1:0]    mode, wsz;
  logic [AW-1:0] base, stride;
  logic [VLW-1:0] vlen;
  logic [IW-1:0] idx_raddr, st_raddr, wr_idx;
  logic [AW-1:0] idx_rdata;
  logic [63:0]   st_rdata, wr_data;
  logic          wr_en, done;

  logic [AW-1:0] ivec [MVL];
  logic [63:0]   svec [MVL];
  logic [63:0]   mdl  [256];

  assign idx_rdata = ivec[idx_raddr];
  assign st_rdata  = svec[st_raddr];

  int n_cmp = 0;
  int n_bad = 0;
  int wr_t [MVL];
  int done_t;
  int n_wr;
  bit poke;

  vec_bank_lsu i_vec_bank_lsu (
    .clk (clk), .rst_n (rst_n), .start_i (start), .store_i (store),
    .mode_i (mode), .wsz_i (wsz), .base_i (base), .stride_i (stride),
    .vlen_i (vlen), .idx_raddr_o (idx_raddr), .idx_rdata_i (idx_rdata),
    .st_raddr_o (st_raddr), .st_rdata_i (st_rdata), .wr_en_o (wr_en),
    .wr_idx_o (wr_idx), .wr_data_o (wr_data), .done_o (done)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] fitb(input logic [63:0] d, input logic [1:0] w);
    case (w)
      2'd0:    return {56'd0, d[7:0]};
      2'd1:    return {48'd0, d[15:0]};
      2'd2:    return {32'd0, d[31:0]};
      default: return d;
    endcase
  endfunction

  // R1 R2 R3 address forms, R5 slot = element address modulo 256 entries
  function automatic int slot_of(input int i, input logic [1:0] m, input logic [1:0] w,
                                 input logic [AW-1:0] b, input logic [AW-1:0] s);
    logic [AW-1:0] a;
    if (m == 2'd2)      a = b + ivec[i];
    else if (m == 2'd1) a = b + AW'(i) * s;
    else                a = b + AW'(i) * (AW'(1) << w);
    return int'((a >> w) & AW'(255));
  endfunction

  task automatic run_op(input bit st, input logic [1:0] m, input logic [1:0] w,
                        input logic [AW-1:0] b, input logic [AW-1:0] s,
                        input int n, input string req);
    logic [63:0] expd [MVL];
    int          slots [MVL];
    for (int i = 0; i < n; i++) begin
      slots[i] = slot_of(i, m, w, b, s);
      expd[i]  = fitb(mdl[slots[i]], w);
    end
    @(negedge clk);
    store = st; mode = m; wsz = w; base = b; stride = s; vlen = VLW'(n); start = 1'b1;
    n_wr = 0;
    done_t = -1;
    for (int t = 1; t <= 800 && done_t < 0; t++) begin
      @(negedge clk);
      if (t == 1) start = 1'b0;
      if (poke && t == 3) begin start = 1'b1; vlen = VLW'(MVL); store = !st; end
      if (poke && t == 4) start = 1'b0;
      if (wr_en) begin
        if (n_wr < MVL) begin
          wr_t[n_wr] = t;
          chk("R8 order", 64'(wr_idx), 64'(n_wr));
          if (!st && n_wr < n) chk(req, wr_data, expd[n_wr]);
        end
        n_wr++;
      end
      if (done) done_t = t;
    end
    if (done_t < 0) chk("R10 done missing", 64'd0, 64'd1);
    chk("R8 write count", 64'(n_wr), st ? 64'd0 : 64'(n));
    if (st) for (int i = 0; i < n; i++) mdl[slots[i]] = fitb(svec[i], w);
    for (int q = 0; q < 6; q++) begin
      @(negedge clk);
      if (done || wr_en) chk("R10 quiet after done", {62'd0, done, wr_en}, 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog: got hang expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    poke = 1'b0;
    rst_n = 1'b0; start = 1'b0; store = 1'b0; mode = '0; wsz = '0;
    base = '0; stride = '0; vlen = '0;
    for (int i = 0; i < MVL; i++) begin ivec[i] = '0; svec[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset done", 64'(done), 64'd0);
    chk("R10 reset wr_en", 64'(wr_en), 64'd0);

    // fill memory with 64-bit unit-stride stores, conflict-free store timing
    for (int k = 0; k < 16; k++) begin
      for (int i = 0; i < MVL; i++) svec[i] = {$urandom, $urandom};
      run_op(1'b1, 2'd0, 2'd3, AW'(k * 128), '0, 16, "R1");
      chk("R10 store done cycle", 64'(done_t), 64'd17);
    end

    // R1 R7 R10: conflict-free 64-bit load
    run_op(1'b0, 2'd0, 2'd3, 16'd0, '0, 16, "R1");
    for (int i = 0; i < 16; i++) chk("R7 write cycle", 64'(wr_t[i]), 64'(13 + i));
    chk("R10 load done cycle", 64'(done_t), 64'd29);

    // R6 R2: 128-byte stride at 64-bit hits one bank
    run_op(1'b0, 2'd1, 2'd3, 16'd24, 16'd128, 5, "R2");
    for (int i = 0; i < 5; i++) chk("R6 same bank spacing", 64'(wr_t[i]), 64'(13 + 4 * i));

    // R5: stride 16 bytes is one bank at 8-bit, spread at 64-bit
    run_op(1'b0, 2'd1, 2'd0, 16'd3, 16'd16, 4, "R5");
    for (int i = 0; i < 4; i++) chk("R5 byte-width bank", 64'(wr_t[i]), 64'(13 + 4 * i));
    run_op(1'b0, 2'd1, 2'd3, 16'd0, 16'd16, 12, "R5");
    for (int i = 0; i < 12; i++) chk("R5 word-width bank", 64'(wr_t[i]), 64'(13 + i));

    // R6: zero stride repeats one location
    run_op(1'b0, 2'd1, 2'd2, 16'd40, 16'd0, 4, "R2");
    for (int i = 0; i < 4; i++) chk("R6 zero stride", 64'(wr_t[i]), 64'(13 + 4 * i));

    // R4: narrow loads and a narrow store read back at full width
    run_op(1'b0, 2'd0, 2'd0, 16'd5, '0, 16, "R4");
    for (int i = 0; i < MVL; i++) svec[i] = {$urandom, $urandom};
    run_op(1'b1, 2'd0, 2'd1, 16'd64, '0, 8, "R4");
    run_op(1'b0, 2'd0, 2'd3, 16'd256, '0, 8, "R4");

    // R3: gather, then scatter with a repeated location
    for (int i = 0; i < MVL; i++) ivec[i] = AW'($urandom);
    run_op(1'b0, 2'd2, 2'd3, 16'd8, '0, 16, "R3");
    for (int i = 0; i < MVL; i++) begin ivec[i] = AW'(i * 8); svec[i] = {$urandom, $urandom}; end
    ivec[5] = 16'd16;
    run_op(1'b1, 2'd2, 2'd3, 16'd512, '0, 8, "R3");
    run_op(1'b0, 2'd0, 2'd3, 16'd512, '0, 8, "R3");

    // R9: zero length store and load
    for (int i = 0; i < MVL; i++) svec[i] = '1;
    run_op(1'b1, 2'd0, 2'd3, 16'd0, '0, 0, "R9");
    chk("R9 store done cycle", 64'(done_t), 64'd2);
    run_op(1'b0, 2'd0, 2'd3, 16'd0, '0, 0, "R9");
    chk("R9 load done cycle", 64'(done_t), 64'd2);
    run_op(1'b0, 2'd0, 2'd3, 16'd0, '0, 16, "R9");

    // R11: start during a running load is ignored
    poke = 1'b1;
    run_op(1'b0, 2'd0, 2'd3, 16'd128, '0, 6, "R11");
    poke = 1'b0;
    chk("R11 done cycle", 64'(done_t), 64'd19);
    run_op(1'b0, 2'd0, 2'd3, 16'd128, '0, 16, "R11");

    // random mix
    for (int r = 0; r < 80; r++) begin
      logic [1:0] m;
      logic [1:0] w;
      bit st;
      int n;
      m  = 2'($urandom_range(0, 3));
      w  = 2'($urandom_range(0, 3));
      st = 1'($urandom_range(0, 1));
      n  = $urandom_range(0, MVL);
      for (int i = 0; i < MVL; i++) begin ivec[i] = AW'($urandom); svec[i] = {$urandom, $urandom}; end
      run_op(st, m, w, AW'($urandom), AW'($urandom), n,
             (m == 2'd1) ? "R2" : (m == 2'd2) ? "R3" : "R1");
    end
    run_op(1'b0, 2'd0, 2'd3, 16'd0, '0, 16, "R4");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule